// File: doc/BRIEF.md
# Shared-Memory Mailbox Interrupt Flags

This block raises and drops the mailbox interrupt of each side of a two-port shared memory. The two highest word addresses are reserved as mailboxes. The lower one of the pair (`0xFFFE` at the default 16-bit address width) belongs to the left side, and the top one (`0xFFFF`) belongs to the right side. When one side writes the other side's mailbox word, the owner of that word gets an interrupt. The owner removes the interrupt by reading its own mailbox word. The message data stays in the ordinary memory array. This block only watches the control strobes and the addresses of both sides.

Each side has active-low strobes for select, read/write direction and output enable. The block keeps one registered flag per side and drives it out as an active-low interrupt line. A mailbox-enable input turns the function off. While it is off, both lines stay inactive and the two words behave as plain storage.

Top module: `mbx_irq_top`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it, both `l_irq_n` and `r_irq_n` are 1.
- R2: A right-side write (`r_sel_n`=0, `r_wr_n`=0) to address all-ones-minus-one (`0xFFFE`) makes `l_irq_n` 0 after the next rising clock edge.
- R3: A left-side read (`l_sel_n`=0, `l_wr_n`=1, `l_oe_n`=0) of `0xFFFE` makes `l_irq_n` 1 after the next edge.
- R4: A left-side write to the all-ones address (`0xFFFF`) makes `r_irq_n` 0 after the next edge.
- R5: A right-side read of `0xFFFF` makes `r_irq_n` 1 after the next edge.
- R6: A write counts only with select=0 and write=0. A read counts only with select=0, write=1 and output enable=0. Any other strobe combination changes no flag.
- R7: A side's accesses to other addresses do not change any flag. Its writes to its own mailbox do not change any flag. Its reads of the other side's mailbox do not change any flag.
- R8: If a flag is set and cleared in the same cycle, the set wins and the line goes or stays at 0.
- R9: With `mbx_en`=0, both lines are 1 after the next edge, and writes to a mailbox set nothing.
- R10: Without a set or a clear, each line keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mbx_en | input | 1 | Mailbox function enable |
| l_sel_n | input | 1 | Left side select, active low |
| l_wr_n | input | 1 | Left side write strobe, active low (high = read) |
| l_oe_n | input | 1 | Left side output enable, active low |
| l_addr | input | ADDR_W | Left side word address |
| r_sel_n | input | 1 | Right side select, active low |
| r_wr_n | input | 1 | Right side write strobe, active low (high = read) |
| r_oe_n | input | 1 | Right side output enable, active low |
| r_addr | input | ADDR_W | Right side word address |
| l_irq_n | output | 1 | Left side interrupt, active low, registered |
| r_irq_n | output | 1 | Right side interrupt, active low, registered |

## Verification
The assertions check every cycle that a mailbox write from the opposite side sets the flag, and that set takes priority over a clear. They also check that an owner read clears the flag, that disabling or reset releases both lines, and that the lines hold when nothing happens. The bench's scenarios are needed to show the negative cases: incomplete strobe combinations, writes by a side to its own mailbox, and reads of the partner's mailbox. A reference model compared every cycle also covers mixed traffic near the top of the address space.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Number of sides sharing the memory; side 0 is left, side 1 is right.
  localparam int NSIDE = 2;
  localparam int SIDE_W = 1;

  typedef enum logic [SIDE_W-1:0] {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  // Decoded strobe state of one side.
  typedef struct packed {
    logic wr;
    logic rd;
  } acc_t;

  function automatic acc_t decode_strobes(input logic sel_n, input logic wr_n,
                                          input logic oe_n);
    acc_t a;
    a.wr = ~sel_n & ~wr_n;
    a.rd = ~sel_n &  wr_n & ~oe_n;
    return a;
  endfunction
endpackage

// File: rtl/mbx_access_dec.sv
module mbx_access_dec
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [NSIDE-1:0]  wr_box,
  output logic [NSIDE-1:0]  rd_box
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  acc_t acc;
  assign acc = decode_strobes(sel_n, wr_n, oe_n);

  // Mailbox b sits at TOP_ADDR - (NSIDE-1-b): the left box is one below the top.
  for (genvar b = 0; b < NSIDE; b++) begin : g_box
    localparam logic [ADDR_W-1:0] BOX_ADDR = TOP_ADDR - ADDR_W'(NSIDE - 1 - b);
    logic hit;
    assign hit       = (addr == BOX_ADDR);
    assign wr_box[b] = acc.wr & hit;
    assign rd_box[b] = acc.rd & hit;
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  logic irq_n_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      irq_n_q <= 1'b1;
    end else if (set) begin
      irq_n_q <= 1'b0;
    end else if (clr) begin
      irq_n_q <= 1'b1;
    end
  end

  assign irq_n = irq_n_q;
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mbx_en,
  input  logic              l_sel_n,
  input  logic              l_wr_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_sel_n,
  input  logic              r_wr_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  logic [NSIDE-1:0]              sel_n_v, wr_n_v, oe_n_v, irq_n_v;
  logic [NSIDE-1:0][ADDR_W-1:0]  addr_v;
  logic [NSIDE-1:0][NSIDE-1:0]   wr_box_v, rd_box_v;

  assign sel_n_v[SIDE_LEFT]  = l_sel_n;
  assign sel_n_v[SIDE_RIGHT] = r_sel_n;
  assign wr_n_v[SIDE_LEFT]   = l_wr_n;
  assign wr_n_v[SIDE_RIGHT]  = r_wr_n;
  assign oe_n_v[SIDE_LEFT]   = l_oe_n;
  assign oe_n_v[SIDE_RIGHT]  = r_oe_n;
  assign addr_v[SIDE_LEFT]   = l_addr;
  assign addr_v[SIDE_RIGHT]  = r_addr;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam int PARTNER = NSIDE - 1 - s;

    mbx_access_dec #(.ADDR_W(ADDR_W)) u_dec (
      .sel_n  (sel_n_v[s]),
      .wr_n   (wr_n_v[s]),
      .oe_n   (oe_n_v[s]),
      .addr   (addr_v[s]),
      .wr_box (wr_box_v[s]),
      .rd_box (rd_box_v[s])
    );

    // Flag s: set by the partner writing box s, cleared by side s reading box s.
    mbx_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .en    (mbx_en),
      .set   (wr_box_v[PARTNER][s]),
      .clr   (rd_box_v[s][s]),
      .irq_n (irq_n_v[s])
    );
  end

  assign l_irq_n = irq_n_v[SIDE_LEFT];
  assign r_irq_n = irq_n_v[SIDE_RIGHT];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mbx_en,
  input logic              l_sel_n,
  input logic              l_wr_n,
  input logic              l_oe_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_sel_n,
  input logic              r_wr_n,
  input logic              r_oe_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_irq_n,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] R_BOX = '1;
  localparam logic [ADDR_W-1:0] L_BOX = R_BOX - ADDR_W'(1);

  logic set_l, clr_l, set_r, clr_r;
  assign set_l = !r_sel_n && !r_wr_n && (r_addr == L_BOX);
  assign clr_l = !l_sel_n && l_wr_n && !l_oe_n && (l_addr == L_BOX);
  assign set_r = !l_sel_n && !l_wr_n && (l_addr == R_BOX);
  assign clr_r = !r_sel_n && r_wr_n && !r_oe_n && (r_addr == R_BOX);

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (l_irq_n && r_irq_n)); // R1
  AST_SET_LEFT: assert property (@(posedge clk) disable iff (rst)
    (mbx_en && set_l) |=> !l_irq_n); // R2
  AST_CLR_LEFT: assert property (@(posedge clk) disable iff (rst)
    (mbx_en && clr_l && !set_l) |=> l_irq_n); // R3
  AST_SET_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (mbx_en && set_r) |=> !r_irq_n); // R4
  AST_CLR_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (mbx_en && clr_r && !set_r) |=> r_irq_n); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (mbx_en && set_l && clr_l) |=> !l_irq_n); // R8
  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !mbx_en |=> (l_irq_n && r_irq_n)); // R9
  AST_HOLD_LEFT: assert property (@(posedge clk) disable iff (rst)
    (mbx_en && !set_l && !clr_l) |=> $stable(l_irq_n)); // R10
  AST_HOLD_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (mbx_en && !set_r && !clr_r) |=> $stable(r_irq_n)); // R10
endmodule

bind mbx_irq_top mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mbx_irq_top_tb.sv
module mbx_irq_top_tb;
  localparam int AW = 16;
  localparam logic [AW-1:0] LB = 16'hFFFE;
  localparam logic [AW-1:0] RB = 16'hFFFF;

  logic clk = 1'b0;
  logic rst, mbx_en;
  logic l_sel_n, l_wr_n, l_oe_n, r_sel_n, r_wr_n, r_oe_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_irq_n, r_irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit exp_l = 1'b0;  // model: flag raised (line low)
  bit exp_r = 1'b0;

  always #5 clk = ~clk;

  mbx_irq_top #(.ADDR_W(AW)) u_dut (.*);

  task automatic check(input string tag);
    checks += 2;
    if (l_irq_n !== !exp_l) begin
      errors++;
      $display("FAIL %s l_irq_n got %0b exp %0b", tag, l_irq_n, !exp_l);
    end
    if (r_irq_n !== !exp_r) begin
      errors++;
      $display("FAIL %s r_irq_n got %0b exp %0b", tag, r_irq_n, !exp_r);
    end
  endtask

  // Left strobes (sel,wr,oe,addr), right strobes, enable; one clock, then compare.
  task automatic cyc(input logic ls, input logic lw, input logic lo, input logic [AW-1:0] la,
                     input logic rs, input logic rw, input logic ro, input logic [AW-1:0] ra,
                     input logic en, input string tag);
    bit l_set, l_clr, r_set, r_clr;
    l_sel_n = ls; l_wr_n = lw; l_oe_n = lo; l_addr = la;
    r_sel_n = rs; r_wr_n = rw; r_oe_n = ro; r_addr = ra;
    mbx_en = en;
    @(posedge clk);
    l_set = (rs == 0) && (rw == 0) && (ra == LB);
    r_set = (ls == 0) && (lw == 0) && (la == RB);
    l_clr = (ls == 0) && (lw == 1) && (lo == 0) && (la == LB);
    r_clr = (rs == 0) && (rw == 1) && (ro == 0) && (ra == RB);
    if (rst || !en) begin
      exp_l = 0; exp_r = 0;
    end else begin
      if (l_set) exp_l = 1; else if (l_clr) exp_l = 0;
      if (r_set) exp_r = 1; else if (r_clr) exp_r = 0;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input string tag);
    cyc(1, 1, 1, 0, 1, 1, 1, 0, 1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    mbx_en = 1'b1;
    l_sel_n = 1; l_wr_n = 1; l_oe_n = 1; l_addr = 0;
    r_sel_n = 1; r_wr_n = 1; r_oe_n = 1; r_addr = 0;
    @(negedge clk);
    cyc(1, 1, 1, 0, 0, 0, 1, LB, 1, "R1 reset with write");
    check("R1 in reset");
    rst = 1'b0;
    idle("R1 after reset");

    cyc(1, 1, 1, 0, 0, 0, 1, LB, 1, "R2 right writes left box");
    idle("R10 left hold"); idle("R10 left hold");
    cyc(1, 1, 1, 0, 0, 1, 0, LB, 1, "R7 right reads left box");
    cyc(0, 0, 0, LB, 1, 1, 1, 0, 1, "R7 left writes own box");
    cyc(0, 1, 0, 16'hFFFD, 1, 1, 1, 0, 1, "R7 left reads other address");
    cyc(0, 1, 1, LB, 1, 1, 1, 0, 1, "R6 read without oe");
    cyc(1, 1, 0, LB, 1, 1, 1, 0, 1, "R6 read without select");
    cyc(0, 1, 0, LB, 1, 1, 1, 0, 1, "R3 left reads own box");
    idle("R10 left cleared hold");

    cyc(0, 0, 1, RB, 1, 1, 1, 0, 1, "R4 left writes right box");
    cyc(1, 1, 1, 0, 0, 0, 1, RB, 1, "R7 right writes own box");
    cyc(0, 1, 0, RB, 1, 1, 1, 0, 1, "R7 left reads right box");
    cyc(1, 1, 1, 0, 0, 1, 0, RB, 1, "R5 right reads own box");
    cyc(1, 1, 1, 0, 0, 1, 1, LB, 1, "R6 right read strobe no set");
    cyc(1, 0, 1, RB, 1, 0, 1, LB, 1, "R6 unselected writes");
    cyc(0, 0, 1, 16'h0000, 0, 0, 1, 16'h7FFE, 1, "R7 writes elsewhere");

    cyc(0, 1, 0, LB, 0, 0, 1, LB, 1, "R8 left set wins");
    cyc(0, 0, 1, RB, 0, 1, 0, RB, 1, "R8 right set wins");
    cyc(1, 1, 1, 0, 1, 1, 1, 0, 0, "R9 disable releases");
    cyc(0, 0, 1, RB, 0, 0, 1, LB, 0, "R9 writes while disabled");
    idle("R9 re-enabled stays idle");

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] la, ra;
      int pick;
      pick = $urandom_range(0, 3);
      la = (pick == 0) ? LB : (pick == 1) ? RB : (pick == 2) ? 16'hFFFD : AW'($urandom);
      pick = $urandom_range(0, 3);
      ra = (pick == 0) ? LB : (pick == 1) ? RB : (pick == 2) ? 16'h0001 : AW'($urandom);
      cyc(1'($urandom), 1'($urandom), 1'($urandom), la,
          1'($urandom), 1'($urandom), 1'($urandom), ra,
          ($urandom_range(0, 15) != 0), "R10 mixed traffic");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule